// File: doc/BRIEF.md
# Mandelbrot escape-count engine

This block takes one point c = (cx, cy) of the complex plane and reports how many steps of the recurrence z ← z² + c the point survives before |z|² exceeds 4, starting from z = 0. It does one step per clock. It gives every point a fixed window of 16 steps, so a pixel generator that runs four clocks per pixel can hand it a new point every fourth pixel and get results back at the same rate.

To save area the two squares and the cross product are formed by column-truncated multipliers. These are within about one least significant bit of the exact product. An overflowing update saturates instead of wrapping, so a large value cannot fold back inside the escape circle. Alongside the count, the block drives a 6-bit colour, 2 bits per primary, taken from a fixed mapping of the count.

Top module: `mandel_engine`

## Requirements
- R1: A start pulse sampled at clock edge E0 while the block is idle is accepted. `done_o` is high for exactly one cycle, right after edge E16. It is low after every edge from E1 to E15.
- R2: Let z0 = 0 and z(k+1) = zk² + c. The count is the smallest k, from 0 to 15, for which the sum of the squares of the parts of zk is strictly greater than 4. If no such k exists, the count is 16 and the point is inside. Since z0 = 0, an escaping point never reports 0.
- R3: `cx_i` and `cy_i`, and the internal z, are two's-complement numbers with 16 bits, 13 of them fractional: a value v is coded as v·8192. The range -4 (0x8000) is accepted and handled.
- R4: Products may differ from the exact product by about one LSB. The count matches an exact-product model exactly, except where some checked |z|² lies within 16 LSB of 4. There a difference of one step is allowed.
- R5: An update whose real or imaginary part leaves the 16-bit range saturates to the nearest extreme. For c = (2, 0) this gives an escape at count 2 (or 1 by R4), never a wrapped point that stays inside.
- R6: The colour is {R, G, B} in bits [5:4], [3:2] and [1:0]. A count of 16 gives 0. Any other count n gives R = n[3:2], G = n[1:0] and B = 3 − n[3:2].
- R7: `count_o` and `colour_o` change only on a cycle where `done_o` is high. They hold their value until the next `done_o`.
- R8: A start pulse while a point is in progress is ignored, with one exception: a start sampled on the same edge that ends a point (E16) is accepted. That allows one point every 16 cycles.
- R9: While reset is asserted, and after it is released, `done_o`, `count_o` and `colour_o` are 0 until the first result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a new point (one-cycle pulse) |
| cx_i | input | 16 | Real part of c, signed, 13 fractional bits |
| cy_i | input | 16 | Imaginary part of c, signed, 13 fractional bits |
| done_o | output | 1 | One-cycle pulse: count and colour are new |
| count_o | output | 5 | Escape count, 16 means inside |
| colour_o | output | 6 | {R[1:0], G[1:0], B[1:0]} from the count |

## Verification
The bench compares each count with an exact-product model. It goes after points that sit exactly on the |z|² = 4 circle, such as c = (1, 0) and c = (2, 0). An engine that wraps instead of saturating reports (2, 0) as inside. One that tests with ≥ rather than > escapes a step early on (1, 0). Starts are issued in the middle of a point and on its final edge. A design that restarts on any start loses the first result, and one that only accepts starts when idle drops every second point of a back-to-back stream. Results are sampled again several cycles after `done_o`, to catch outputs that drift between results, and colour is checked for both inside and escaping counts.

// File: rtl/mandel_pkg.sv
`timescale 1ns/1ps
package mandel_pkg;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned FRAC_W     = 13;
  localparam int unsigned ITERS      = 16;
  localparam int unsigned TRUNC_COLS = 9;

  localparam int unsigned COUNT_W = $clog2(ITERS + 1);
  localparam int unsigned STEP_W  = $clog2(ITERS);
  localparam int unsigned MAG_W   = DATA_W - 1;
  localparam int unsigned PROD_W  = 2 * MAG_W;
  localparam int unsigned PR_W    = PROD_W + 1 - FRAC_W;
  localparam int unsigned EXT_W   = PR_W + 3;

  typedef logic signed [DATA_W-1:0] fx_t;
  typedef logic [COUNT_W-1:0]       count_t;
  typedef logic [5:0]               rgb_t;

  function automatic rgb_t colour_of(count_t c);
    rgb_t r;
    if (c >= COUNT_W'(ITERS)) r = '0;
    else r = {c[3:2], c[1:0], 2'd3 - c[3:2]};
    return r;
  endfunction
endpackage

// File: rtl/mandel_rst_sync.sv
`timescale 1ns/1ps
module mandel_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/mandel_approx_mul.sv
`timescale 1ns/1ps
module mandel_approx_mul
  import mandel_pkg::*;
(
  input  fx_t                      a,
  input  fx_t                      b,
  output logic signed [PR_W:0]     p
);
  localparam logic [PROD_W-1:0] KEEP_MASK = ~((PROD_W'(1) << TRUNC_COLS) - PROD_W'(1));
  localparam logic [PROD_W:0]   COMP      = (PROD_W + 1)'(1) << (TRUNC_COLS + 1);
  localparam logic [FRAC_W-1:0] HALF      = FRAC_W'(1) << (FRAC_W - 1);
  localparam fx_t               MOST_NEG  = {1'b1, {(DATA_W-1){1'b0}}};

  logic [MAG_W-1:0]  ma, mb;
  logic              neg;
  logic [PROD_W-1:0] pp [MAG_W];
  logic [PROD_W:0]   acc;
  logic [PR_W-1:0]   acc_hi;
  logic [FRAC_W-1:0] acc_lo;
  logic [PR_W-1:0]   umag;

  always_comb begin
    if (!a[DATA_W-1])        ma = a[MAG_W-1:0];
    else if (a == MOST_NEG)  ma = '1;
    else                     ma = MAG_W'(-a);
    if (!b[DATA_W-1])        mb = b[MAG_W-1:0];
    else if (b == MOST_NEG)  mb = '1;
    else                     mb = MAG_W'(-b);
  end

  assign neg = a[DATA_W-1] ^ b[DATA_W-1];

  for (genvar i = 0; i < MAG_W; i++) begin : g_pp
    assign pp[i] = ma[i] ? ((PROD_W'(mb) << i) & KEEP_MASK) : '0;
  end

  always_comb begin
    acc = COMP;
    for (int i = 0; i < MAG_W; i++) acc = acc + (PROD_W + 1)'(pp[i]);
  end

  assign {acc_hi, acc_lo} = acc;
  assign umag = acc_hi + PR_W'(acc_lo > HALF);
  assign p    = neg ? -signed'({1'b0, umag}) : signed'({1'b0, umag});
endmodule

// File: rtl/mandel_step.sv
`timescale 1ns/1ps
module mandel_step
  import mandel_pkg::*;
(
  input  fx_t  zx,
  input  fx_t  zy,
  input  fx_t  cx,
  input  fx_t  cy,
  output logic escape,
  output fx_t  nx,
  output fx_t  ny
);
  localparam logic signed [EXT_W-1:0] LIMIT = EXT_W'(4) <<< FRAC_W;

  logic signed [PR_W:0]    xx, yy, xy;
  logic signed [EXT_W-1:0] mag, nx_w, ny_w;

  mandel_approx_mul u_xx (.a(zx), .b(zx), .p(xx));
  mandel_approx_mul u_yy (.a(zy), .b(zy), .p(yy));
  mandel_approx_mul u_xy (.a(zx), .b(zy), .p(xy));

  function automatic fx_t clip(logic signed [EXT_W-1:0] v);
    fx_t r;
    if ((v[EXT_W-1:DATA_W-1] == '0) || (v[EXT_W-1:DATA_W-1] == '1))
      r = v[DATA_W-1:0];
    else if (v[EXT_W-1])
      r = {1'b1, {(DATA_W-1){1'b0}}};
    else
      r = {1'b0, {(DATA_W-1){1'b1}}};
    return r;
  endfunction

  always_comb begin
    mag    = EXT_W'(xx) + EXT_W'(yy);
    escape = mag > LIMIT;
    nx_w   = EXT_W'(xx) - EXT_W'(yy) + EXT_W'(cx);
    ny_w   = (EXT_W'(xy) <<< 1) + EXT_W'(cy);
    nx     = clip(nx_w);
    ny     = clip(ny_w);
  end
endmodule

// File: rtl/mandel_engine.sv
`timescale 1ns/1ps
module mandel_engine
  import mandel_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [DATA_W-1:0]   cx_i,
  input  logic [DATA_W-1:0]   cy_i,
  output logic                done_o,
  output logic [COUNT_W-1:0]  count_o,
  output logic [5:0]          colour_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(ITERS - 1);

  logic rst_sync_n;

  logic              busy_q, busy_d;
  logic [STEP_W-1:0] step_q, step_d;
  fx_t               zx_q, zx_d, zy_q, zy_d;
  fx_t               cx_q, cx_d, cy_q, cy_d;
  logic              esc_q, esc_d;
  count_t            pass_q, pass_d;
  logic              done_q, done_d;
  count_t            count_q, count_d;
  rgb_t              colour_q, colour_d;

  logic   escape_now, pass_now, last, accept;
  fx_t    nx, ny;
  count_t final_cnt;

  mandel_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(rst_sync_n));

  mandel_step u_step (
    .zx(zx_q), .zy(zy_q), .cx(cx_q), .cy(cy_q),
    .escape(escape_now), .nx(nx), .ny(ny)
  );

  assign last      = busy_q && (step_q == LAST_STEP);
  assign accept    = start_i && (!busy_q || last);
  assign pass_now  = busy_q && !esc_q && !escape_now;
  assign final_cnt = pass_q + COUNT_W'(pass_now);

  always_comb begin
    busy_d   = busy_q;
    step_d   = step_q;
    zx_d     = zx_q;
    zy_d     = zy_q;
    cx_d     = cx_q;
    cy_d     = cy_q;
    esc_d    = esc_q;
    pass_d   = pass_q;
    done_d   = 1'b0;
    count_d  = count_q;
    colour_d = colour_q;

    if (busy_q) begin
      step_d = step_q + STEP_W'(1);
      if (!esc_q) begin
        if (escape_now) begin
          esc_d = 1'b1;
        end else begin
          zx_d   = nx;
          zy_d   = ny;
          pass_d = pass_q + COUNT_W'(1);
        end
      end
      if (last) begin
        busy_d   = 1'b0;
        done_d   = 1'b1;
        count_d  = final_cnt;
        colour_d = colour_of(final_cnt);
      end
    end

    if (accept) begin
      busy_d = 1'b1;
      step_d = '0;
      zx_d   = '0;
      zy_d   = '0;
      cx_d   = fx_t'(cx_i);
      cy_d   = fx_t'(cy_i);
      esc_d  = 1'b0;
      pass_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      busy_q   <= 1'b0;
      step_q   <= '0;
      zx_q     <= '0;
      zy_q     <= '0;
      cx_q     <= '0;
      cy_q     <= '0;
      esc_q    <= 1'b0;
      pass_q   <= '0;
      done_q   <= 1'b0;
      count_q  <= '0;
      colour_q <= '0;
    end else begin
      busy_q   <= busy_d;
      step_q   <= step_d;
      zx_q     <= zx_d;
      zy_q     <= zy_d;
      cx_q     <= cx_d;
      cy_q     <= cy_d;
      esc_q    <= esc_d;
      pass_q   <= pass_d;
      done_q   <= done_d;
      count_q  <= count_d;
      colour_q <= colour_d;
    end
  end

  assign done_o   = done_q;
  assign count_o  = count_q;
  assign colour_o = colour_q;
endmodule

// File: rtl/mandel_engine_chk.sv
`timescale 1ns/1ps
module mandel_engine_chk
  import mandel_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               done_o,
  input logic [COUNT_W-1:0] count_o,
  input logic [5:0]         colour_o
);
  // R1 / R7: the result strobe never lasts two cycles
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: results move only together with the strobe
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(count_o) && $stable(colour_o)));

  // R2: a reported count lies between 1 and the step budget
  a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((count_o >= COUNT_W'(1)) && (count_o <= COUNT_W'(ITERS))));

  // R6: inside points are dark
  a_r6_inside_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (count_o == COUNT_W'(ITERS))) |-> (colour_o == 6'd0));

  // R6: escaping points are never dark
  a_r6_escape_lit: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (count_o < COUNT_W'(ITERS))) |-> (colour_o != 6'd0));

  // R9: no result while reset is asserted
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!done_o && (count_o == '0) && (colour_o == '0)));
endmodule

bind mandel_engine mandel_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done_o(done_o), .count_o(count_o), .colour_o(colour_o)
);

// File: tb/tb_mandel_engine.sv
`timescale 1ns/1ps
module tb_mandel_engine;
  import mandel_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int ONE = 8192;

  logic   clk = 1'b0;
  logic   rst_n = 1'b0;
  logic   start = 1'b0;
  fx_t    cx = '0, cy = '0;
  logic   done;
  count_t cnt;
  rgb_t   col;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mandel_engine dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cx_i(cx), .cy_i(cy),
    .done_o(done), .count_o(cnt), .colour_o(col)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sat16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // exact-product model of R2/R5, flags any check within 16 LSB of the limit
  task automatic model(int px, int py, output int n, output bit near);
    int x = 0, y = 0, xx, yy, m;
    n = 16;
    near = 1'b0;
    for (int k = 0; k < 16; k++) begin
      xx = (x * x) >>> 13;
      yy = (y * y) >>> 13;
      m  = xx + yy;
      if ((m - 32768 <= 16) && (32768 - m <= 16)) near = 1'b1;
      if (m > 32768) begin
        n = k;
        break;
      end
      y = sat16(2 * ((x * y) >>> 13) + py);
      x = sat16(xx - yy + px);
    end
  endtask

  function automatic rgb_t want_colour(int n);
    logic [4:0] c = n[4:0];
    if (n >= 16) return 6'd0;
    return {c[3:2], c[1:0], 2'd3 - c[3:2]};
  endfunction

  task automatic launch(int px, int py);
    @(negedge clk);
    start = 1'b1;
    cx = fx_t'(px);
    cy = fx_t'(py);
    @(negedge clk);
    start = 1'b0;
  endtask

  // called at N0; optionally raises start at step inj (1..15); returns at N16
  task automatic await_result(int px, int py, int inj, int ix, int iy, string tag);
    int n;
    bit near, early = 1'b0, ok;
    model(px, py, n, near);
    for (int k = 1; k <= 15; k++) begin
      @(negedge clk);
      if (done) early = 1'b1;
      if (k == inj) begin
        start = 1'b1;
        cx = fx_t'(ix);
        cy = fx_t'(iy);
      end else begin
        start = 1'b0;
      end
    end
    @(negedge clk);
    start = 1'b0;
    check(!early, "R1", {tag, " early done"}, int'(early), 0);
    check(done == 1'b1, "R1", {tag, " done at 16"}, int'(done), 1);
    if (near) ok = (int'(cnt) - n <= 1) && (n - int'(cnt) <= 1);
    else      ok = (int'(cnt) == n);
    check(ok, near ? "R4" : "R2", {tag, " count"}, int'(cnt), n);
    check(col == want_colour(int'(cnt)), "R6", {tag, " colour"}, int'(col), int'(want_colour(int'(cnt))));
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R9", "done in reset", int'(done), 0);
    check(cnt == '0, "R9", "count in reset", int'(cnt), 0);
    check(col == '0, "R9", "colour in reset", int'(col), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check((done == 1'b0) && (cnt == '0), "R9", "idle after release", int'(cnt), 0);
  endtask

  task automatic test_inside();
    launch(0, 0);              await_result(0, 0, 0, 0, 0, "R3 origin");
    launch(-ONE, 0);           await_result(-ONE, 0, 0, 0, 0, "period-two");
    launch(0, ONE);            await_result(0, ONE, 0, 0, 0, "unit-i");
    launch(ONE/4, 0);          await_result(ONE/4, 0, 0, 0, 0, "cusp");
    launch(-3*ONE/2, 0);       await_result(-3*ONE/2, 0, 0, 0, 0, "real-axis");
    launch(-ONE/2, ONE/2);     await_result(-ONE/2, ONE/2, 0, 0, 0, "bulb");
  endtask

  task automatic test_escape();
    launch(ONE/2, 0);          await_result(ONE/2, 0, 0, 0, 0, "R2 half");
    launch(2*ONE, 2*ONE);      await_result(2*ONE, 2*ONE, 0, 0, 0, "far");
    launch(-32768, -32768);    await_result(-32768, -32768, 0, 0, 0, "R3 most-negative");
    launch(0, -3*ONE/2);       await_result(0, -3*ONE/2, 0, 0, 0, "imag");
    launch(ONE, 0);            await_result(ONE, 0, 0, 0, 0, "R4 on-circle");
  endtask

  task automatic test_overflow();
    launch(2*ONE, 0);
    await_result(2*ONE, 0, 0, 0, 0, "R5 saturate");
    check(cnt != 5'd16, "R5", "wrapped to inside", int'(cnt), 2);
  endtask

  task automatic test_hold();
    count_t c0;
    rgb_t   k0;
    bit     moved = 1'b0, strobe = 1'b0;
    launch(ONE/2, 0);
    await_result(ONE/2, 0, 0, 0, 0, "R7 hold");
    c0 = cnt;
    k0 = col;
    repeat (6) begin
      @(negedge clk);
      if (done) strobe = 1'b1;
      if ((cnt != c0) || (col != k0)) moved = 1'b1;
    end
    check(!strobe, "R7", "done longer than one cycle", int'(strobe), 0);
    check(!moved, "R7", "outputs moved between results", int'(cnt), int'(c0));
  endtask

  task automatic test_busy_ignore();
    bit extra = 1'b0;
    launch(ONE/2, 0);
    await_result(ONE/2, 0, 5, 2*ONE, 2*ONE, "R8 mid start");
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (done) extra = 1'b1;
    end
    check(!extra, "R8", "mid-point start was taken", int'(extra), 0);
  endtask

  task automatic test_back_to_back();
    launch(0, 0);
    await_result(0, 0, 15, 2*ONE, 2*ONE, "R8 first");
    await_result(2*ONE, 2*ONE, 0, 0, 0, "R8 second");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_inside();
    test_escape();
    test_overflow();
    test_hold();
    test_busy_ignore();
    test_back_to_back();
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule